// File: doc/BRIEF.md
# Sixteen-Bit ALU Datapath with Flag Update

This block is the arithmetic and logic datapath of a small 16-bit microcontroller core. It receives a source operand, a destination operand, the current carry flag, a byte/word select, a 12-bit control word and a one-hot single-operand code. It returns a result, new values for the negative (N), zero (Z), carry (C) and overflow (V) flags, one update enable per flag, and an enable that says whether the result should be written back.

Operations are not selected by an opcode. Each control bit enables one independent piece of the datapath. One bit inverts the source. Two bits add a constant one or the incoming carry. The remaining select bits pick a functional unit: binary adder, decimal adder, AND, OR, XOR or the right-shift path. When no unit is selected, the single-operand code picks byte swap or sign extension; with neither, the source is moved through unchanged. The sequencer of the core builds every instruction from these bits. For example, subtract is an inverted source plus one through the adder, and bit-clear is AND with an inverted source.

All outputs are registered once. The results of the inputs present at one rising clock edge appear at the outputs just after that edge. A synchronous active-low reset clears every output.

Top module: `alu16_core`

## Requirements
- R1: With control bit 3 set, the result is dst + S + k, where S is the source (inverted when bit 0 is set) and k is 1 when bit 1 is set, or when bit 2 is set and carry_i is 1. C is the carry out of the sign bit.
- R2: Bits 0, 1 and 3 together give dst − src. C is 1 when no borrow occurs. Bits 0, 2 and 3 give subtract-with-carry, using carry_i in place of the constant one.
- R3: Control bit 7 adds dst, src and the carry term as packed BCD, one 4-bit digit at a time. A digit sum above 9 is corrected by +6 and carries into the next digit. C is the carry out of the top digit in use.
- R4: Control bits 4, 5 and 6 select AND, OR and XOR of dst with the (optionally inverted) source. AND with bit 0 set clears the source bits in dst.
- R5: Control bit 10 shifts the source right by one. The vacated MSB takes carry_i when single-operand bit 0 (rotate through carry) is set. It repeats the old MSB when single-operand bit 2 (arithmetic) is set. C takes the bit shifted out and V is 0.
- R6: When no unit bit (3–7, 10) is set, the result is as follows. Single-operand bit 1 swaps the two bytes of the source. Single-operand bit 3 sign-extends its low byte. Otherwise the result is the source. sop_i carries at most one set bit.
- R7: With byte_i set, only the low 8 bits take part. The upper result byte is 0, N is bit 7, Z tests the low byte, and C is the carry out of bit 7.
- R8: Control bit 9 enables updates of all four flags. Bit 8 enables N, Z and C and forces C to the inverse of Z. With neither set, no flag update is enabled.
- R9: N is the result sign bit and Z is 1 for a zero result. For the adder, V is 1 when both addends share a sign that the result lacks. For XOR, V is 1 when both operands are negative. Otherwise V is 0. For logic, swap, sign-extend and move, C is the inverse of Z.
- R10: dst_wr_o is the inverse of control bit 11.
- R11: Every output reflects the inputs sampled at the previous rising edge. While rst_n is 0 at an edge, all outputs become 0.
- R12: When several unit bits are set, priority is decimal, then adder, AND, OR, XOR and shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| carry_i | input | 1 | Current carry flag |
| byte_i | input | 1 | 1 = byte operation on low 8 bits |
| ctl_i | input | 12 | Control word of independent enables |
| sop_i | input | 8 | One-hot single-operand code |
| res_o | output | 16 | Registered result |
| n_o | output | 1 | New negative flag |
| z_o | output | 1 | New zero flag |
| c_o | output | 1 | New carry flag |
| v_o | output | 1 | New overflow flag |
| n_upd_o | output | 1 | Update enable for N |
| z_upd_o | output | 1 | Update enable for Z |
| c_upd_o | output | 1 | Update enable for C |
| v_upd_o | output | 1 | Update enable for V |
| dst_wr_o | output | 1 | Write-back enable for the result |

## Verification
Every result, flag, flag enable and write enable is due exactly one rising edge after its inputs are applied, because the datapath is combinational up to a single output register. The bench applies each vector on a falling edge and compares all outputs on the next falling edge, with one rising edge in between. One directed test also samples just before that edge, to show the outputs still hold the previous vector's values. Flag values are compared only where the matching update enable is expected to be set. The enables themselves are always compared.

// File: rtl/alu16_pkg.sv
// Shared encodings for the ALU datapath: control-word bit positions,
// single-operand code positions, unit selection and the flag bundle.
// Assumes the control word and single-operand code widths are fixed by
// the sequencer that drives this block.
package alu16_pkg;
    localparam int CTL_W  = 12;
    localparam int SOP_W  = 8;

    // Control-word bit positions (the sequencer depends on this order)
    localparam int CB_INV  = 0;
    localparam int CB_INC  = 1;
    localparam int CB_CIN  = 2;
    localparam int CB_ADD  = 3;
    localparam int CB_AND  = 4;
    localparam int CB_OR   = 5;
    localparam int CB_XOR  = 6;
    localparam int CB_DEC  = 7;
    localparam int CB_NZC  = 8;
    localparam int CB_ALLF = 9;
    localparam int CB_SHR  = 10;
    localparam int CB_NOWR = 11;

    // Single-operand one-hot positions used by the datapath
    localparam int SO_RRC  = 0;
    localparam int SO_SWAP = 1;
    localparam int SO_RRA  = 2;
    localparam int SO_SXT  = 3;

    typedef enum logic [3:0] {
        U_MOVE, U_ADD, U_DEC, U_AND, U_OR, U_XOR, U_SHR, U_SWAP, U_SXT
    } unit_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/alu16_adder.sv
// Binary adder with carry and signed-overflow outputs.
// Assumes the operands are already masked to the low half in byte mode.
module alu16_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int HALF = W / 2;

    logic [W:0] full;
    logic       sa, sb, sr;

    // Full-width sum with one extra bit for the word-mode carry
    always_comb begin
        full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end

    // Pick the carry and sign positions for the selected width
    always_comb begin
        sa     = byte_i ? a_i[HALF-1]  : a_i[W-1];
        sb     = byte_i ? b_i[HALF-1]  : b_i[W-1];
        sr     = byte_i ? full[HALF-1] : full[W-1];
        cout_o = byte_i ? full[HALF]   : full[W];
        ovf_o  = (sa == sb) && (sr != sa);
        sum_o  = full[W-1:0];
    end
endmodule

// File: rtl/alu16_decimal.sv
// Packed-BCD adder: one corrected 4-bit digit stage per nibble, with the
// carry rippling upward. Assumes operands are masked in byte mode.
module alu16_decimal #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         byte_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int DIG      = W / 4;
    localparam int HALF_DIG = DIG / 2;

    logic [DIG:0] cy;

    assign cy[0] = cin_i;

    for (genvar i = 0; i < DIG; i++) begin : g_digit
        logic [4:0] raw;
        // Binary digit sum, then decimal correction above nine
        assign raw              = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'b0, cy[i]};
        assign cy[i+1]          = (raw > 5'd9);
        assign sum_o[4*i +: 4]  = cy[i+1] ? (raw[3:0] + 4'd6) : raw[3:0];
    end

    // Carry out of the highest digit in use
    assign cout_o = byte_i ? cy[HALF_DIG] : cy[DIG];
endmodule

// File: rtl/alu16_bitops.sv
// Logic units, right shift/rotate, byte swap and sign extension.
// Assumes b_i is the prepared source and both operands are masked in
// byte mode; shift results get their MSB placed at the active sign bit.
module alu16_bitops #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         carry_i,
    input  logic         arith_i,
    input  logic         byte_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] shr_o,
    output logic         shr_c_o,
    output logic [W-1:0] swap_o,
    output logic [W-1:0] sxt_o
);
    localparam int HALF = W / 2;

    logic msb_in;

    // Bitwise units
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        xor_o = a_i ^ b_i;
    end

    // Right shift: vacated sign bit takes carry or the old sign
    always_comb begin
        msb_in  = arith_i ? (byte_i ? b_i[HALF-1] : b_i[W-1]) : carry_i;
        shr_o   = {1'b0, b_i[W-1:1]};
        if (byte_i) shr_o[HALF-1] = msb_in;
        else        shr_o[W-1]    = msb_in;
        shr_c_o = b_i[0];
    end

    // Byte swap and sign extension of the low half
    always_comb begin
        swap_o = {b_i[HALF-1:0], b_i[W-1:HALF]};
        sxt_o  = {{HALF{b_i[HALF-1]}}, b_i[HALF-1:0]};
    end
endmodule

// File: rtl/alu16_core.sv
// ALU datapath top: prepares operands, selects a unit by priority,
// masks byte results, derives flags and registers all outputs once.
// Assumes ctl_i/sop_i are driven by the core sequencer; sop_i is one-hot
// or zero. Synchronous active-low reset clears every output.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     src_i,
    input  logic [W-1:0]     dst_i,
    input  logic             carry_i,
    input  logic             byte_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [SOP_W-1:0] sop_i,
    output logic [W-1:0]     res_o,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o,
    output logic             n_upd_o,
    output logic             z_upd_o,
    output logic             c_upd_o,
    output logic             v_upd_o,
    output logic             dst_wr_o
);
    localparam int HALF = W / 2;
    localparam logic [W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic [W-1:0] src_p, opa, opb;
    logic         cin;
    unit_e        sel;

    logic [W-1:0] add_r, dec_r, and_r, or_r, xor_r, shr_r, swap_r, sxt_r;
    logic         add_c, add_v, dec_c, shr_c;

    logic [W-1:0] res_raw, res_m;
    flags_t       fl;

    // Operand preparation: optional source inversion, byte masking, carry term
    always_comb begin
        src_p = ctl_i[CB_INV] ? ~src_i : src_i;
        opa   = byte_i ? (dst_i & LOW_MASK) : dst_i;
        opb   = byte_i ? (src_p & LOW_MASK) : src_p;
        cin   = ctl_i[CB_INC] | (ctl_i[CB_CIN] & carry_i);
    end

    // Unit selection by fixed priority
    always_comb begin
        if      (ctl_i[CB_DEC])   sel = U_DEC;
        else if (ctl_i[CB_ADD])   sel = U_ADD;
        else if (ctl_i[CB_AND])   sel = U_AND;
        else if (ctl_i[CB_OR])    sel = U_OR;
        else if (ctl_i[CB_XOR])   sel = U_XOR;
        else if (ctl_i[CB_SHR])   sel = U_SHR;
        else if (sop_i[SO_SWAP])  sel = U_SWAP;
        else if (sop_i[SO_SXT])   sel = U_SXT;
        else                      sel = U_MOVE;
    end

    alu16_adder #(.W(W)) adder_i (
        .a_i(opa), .b_i(opb), .cin_i(cin), .byte_i(byte_i),
        .sum_o(add_r), .cout_o(add_c), .ovf_o(add_v)
    );

    alu16_decimal #(.W(W)) decimal_i (
        .a_i(opa), .b_i(opb), .cin_i(cin), .byte_i(byte_i),
        .sum_o(dec_r), .cout_o(dec_c)
    );

    alu16_bitops #(.W(W)) bitops_i (
        .a_i(opa), .b_i(opb), .carry_i(carry_i), .arith_i(sop_i[SO_RRA]),
        .byte_i(byte_i),
        .and_o(and_r), .or_o(or_r), .xor_o(xor_r),
        .shr_o(shr_r), .shr_c_o(shr_c), .swap_o(swap_r), .sxt_o(sxt_r)
    );

    // Result multiplexer and byte-mode upper-half clearing
    always_comb begin
        case (sel)
            U_ADD:   res_raw = add_r;
            U_DEC:   res_raw = dec_r;
            U_AND:   res_raw = and_r;
            U_OR:    res_raw = or_r;
            U_XOR:   res_raw = xor_r;
            U_SHR:   res_raw = shr_r;
            U_SWAP:  res_raw = swap_r;
            U_SXT:   res_raw = sxt_r;
            default: res_raw = opb;
        endcase
        res_m = byte_i ? (res_raw & LOW_MASK) : res_raw;
    end

    // Flag values for the selected unit
    always_comb begin
        fl.z = (res_m == '0);
        fl.n = byte_i ? res_m[HALF-1] : res_m[W-1];
        if (ctl_i[CB_NZC]) begin
            fl.c = ~fl.z;
        end else begin
            case (sel)
                U_ADD:   fl.c = add_c;
                U_DEC:   fl.c = dec_c;
                U_SHR:   fl.c = shr_c;
                default: fl.c = ~fl.z;
            endcase
        end
        case (sel)
            U_ADD:   fl.v = add_v;
            U_XOR:   fl.v = byte_i ? (opa[HALF-1] & opb[HALF-1]) : (opa[W-1] & opb[W-1]);
            default: fl.v = 1'b0;
        endcase
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o    <= '0;
            n_o      <= 1'b0;
            z_o      <= 1'b0;
            c_o      <= 1'b0;
            v_o      <= 1'b0;
            n_upd_o  <= 1'b0;
            z_upd_o  <= 1'b0;
            c_upd_o  <= 1'b0;
            v_upd_o  <= 1'b0;
            dst_wr_o <= 1'b0;
        end else begin
            res_o    <= res_m;
            n_o      <= fl.n;
            z_o      <= fl.z;
            c_o      <= fl.c;
            v_o      <= fl.v;
            n_upd_o  <= ctl_i[CB_NZC] | ctl_i[CB_ALLF];
            z_upd_o  <= ctl_i[CB_NZC] | ctl_i[CB_ALLF];
            c_upd_o  <= ctl_i[CB_NZC] | ctl_i[CB_ALLF];
            v_upd_o  <= ctl_i[CB_ALLF];
            dst_wr_o <= ~ctl_i[CB_NOWR];
        end
    end

    // Byte mode leaves the upper result half at zero
    p_byte_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(byte_i)) |-> (res_o[W-1:HALF] == '0));

    // No-write control bit blocks write-back
    p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_i[CB_NOWR])) |-> !dst_wr_o);

    // Without either flag-control bit, no flag may change
    p_quiet_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl_i[CB_NZC]) && !$past(ctl_i[CB_ALLF]))
        |-> !(n_upd_o || z_upd_o || c_upd_o || v_upd_o));

    // Logic-test flag mode: carry is the inverse of zero
    p_carry_not_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_i[CB_NZC])) |-> (c_o == !z_o));

    // Zero flag agrees with the registered result
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (z_o == (res_o == '0)));

    // Shift path always clears overflow
    p_shift_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel == U_SHR)) |-> !v_o);

    // Single-operand code carries at most one set bit
    p_sop_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sop_i));
endmodule

// File: tb/alu16_core_tb_top.sv
`timescale 1ns/1ps
module alu16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_i = '0, dst_i = '0;
    logic        carry_i = 1'b0, byte_i = 1'b0;
    logic [11:0] ctl_i = '0;
    logic [7:0]  sop_i = '0;
    logic [15:0] res_o;
    logic        n_o, z_o, c_o, v_o, n_upd_o, z_upd_o, c_upd_o, v_upd_o, dst_wr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    alu16_core dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i),
        .carry_i(carry_i), .byte_i(byte_i), .ctl_i(ctl_i), .sop_i(sop_i),
        .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
        .n_upd_o(n_upd_o), .z_upd_o(z_upd_o), .c_upd_o(c_upd_o),
        .v_upd_o(v_upd_o), .dst_wr_o(dst_wr_o)
    );

    typedef struct packed {
        logic [11:0] ctl;
        logic [7:0]  sop;
        logic        byt;
        logic        cy;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] res;
        logic [3:0]  flg;   // {N,Z,C,V}
        logic [3:0]  upd;   // {N,Z,C,V} update enables
        logic        wr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    // ctl, sop, byte, carry, src, dst, result, flags, enables, write, requirement
    localparam vec_t VECS [NV] = '{
        '{12'h208, 8'h00, 1'b0, 1'b0, 16'h1234, 16'h0F0F, 16'h2143, 4'b0000, 4'hF, 1'b1, 8'd1},  // R1 add
        '{12'h208, 8'h00, 1'b0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 4'b1001, 4'hF, 1'b1, 8'd9},  // R9 add overflow
        '{12'h208, 8'h00, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 4'b0110, 4'hF, 1'b1, 8'd2},  // R2 carry out
        '{12'h20C, 8'h00, 1'b0, 1'b1, 16'h0001, 16'h0002, 16'h0004, 4'b0000, 4'hF, 1'b1, 8'd1},  // R1 add with carry
        '{12'h20B, 8'h00, 1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0002, 4'b0010, 4'hF, 1'b1, 8'd2},  // R2 subtract
        '{12'hA0B, 8'h00, 1'b0, 1'b0, 16'h8000, 16'h8000, 16'h0000, 4'b0110, 4'hF, 1'b0, 8'd10}, // R10 compare
        '{12'h20B, 8'h00, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 4'b0011, 4'hF, 1'b1, 8'd2},  // R2 subtract overflow
        '{12'h20D, 8'h00, 1'b0, 1'b0, 16'h0003, 16'h0003, 16'hFFFF, 4'b1000, 4'hF, 1'b1, 8'd2},  // R2 subtract with borrow
        '{12'h284, 8'h00, 1'b0, 1'b0, 16'h0001, 16'h0199, 16'h0200, 4'b0000, 4'hF, 1'b1, 8'd3},  // R3 decimal
        '{12'h284, 8'h00, 1'b0, 1'b1, 16'h0000, 16'h9999, 16'h0000, 4'b0110, 4'hF, 1'b1, 8'd3},  // R3 decimal ripple
        '{12'h310, 8'h00, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 4'b0010, 4'hF, 1'b1, 8'd4},  // R4 and
        '{12'hB10, 8'h00, 1'b0, 1'b0, 16'h00FF, 16'hFF00, 16'h0000, 4'b0100, 4'hF, 1'b0, 8'd8},  // R8 bit test
        '{12'h011, 8'h00, 1'b0, 1'b0, 16'h000F, 16'h00FF, 16'h00F0, 4'b0000, 4'h0, 1'b1, 8'd4},  // R4 bit clear
        '{12'h020, 8'h00, 1'b0, 1'b0, 16'h0F00, 16'h00F0, 16'h0FF0, 4'b0000, 4'h0, 1'b1, 8'd8},  // R8 or, no flags
        '{12'h240, 8'h00, 1'b0, 1'b0, 16'h8001, 16'h8003, 16'h0002, 4'b0011, 4'hF, 1'b1, 8'd9},  // R9 xor overflow
        '{12'h000, 8'h00, 1'b0, 1'b0, 16'hABCD, 16'h1111, 16'hABCD, 4'b0000, 4'h0, 1'b1, 8'd6},  // R6 move
        '{12'h600, 8'h01, 1'b0, 1'b1, 16'h0003, 16'h0000, 16'h8001, 4'b1010, 4'hF, 1'b1, 8'd5},  // R5 rotate
        '{12'h600, 8'h04, 1'b0, 1'b0, 16'h8004, 16'h0000, 16'hC002, 4'b1000, 4'hF, 1'b1, 8'd5},  // R5 arith shift
        '{12'h000, 8'h02, 1'b0, 1'b0, 16'h12AB, 16'h0000, 16'hAB12, 4'b0000, 4'h0, 1'b1, 8'd6},  // R6 swap
        '{12'h300, 8'h08, 1'b0, 1'b0, 16'h0080, 16'h0000, 16'hFF80, 4'b1010, 4'hF, 1'b1, 8'd6},  // R6 sign extend
        '{12'h208, 8'h00, 1'b1, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 4'b0110, 4'hF, 1'b1, 8'd7},  // R7 byte carry
        '{12'h208, 8'h00, 1'b1, 1'b0, 16'h007F, 16'hAA01, 16'h0080, 4'b1001, 4'hF, 1'b1, 8'd7},  // R7 byte overflow
        '{12'h600, 8'h01, 1'b1, 1'b1, 16'hFF02, 16'h0000, 16'h0081, 4'b1000, 4'hF, 1'b1, 8'd7},  // R7 byte rotate
        '{12'h284, 8'h00, 1'b1, 1'b0, 16'h0001, 16'h0099, 16'h0000, 4'b0110, 4'hF, 1'b1, 8'd7},  // R7 byte decimal
        '{12'h018, 8'h00, 1'b0, 1'b0, 16'h0003, 16'h0005, 16'h0008, 4'b0000, 4'h0, 1'b1, 8'd12}, // R12 priority
        '{12'h110, 8'h00, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 4'b0100, 4'hE, 1'b1, 8'd8}   // R8 NZC only
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        ctl_i = v.ctl; sop_i = v.sop; byte_i = v.byt; carry_i = v.cy;
        src_i = v.src; dst_i = v.dst;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] fa, ua;
        string tag;
        // R11: reset clears outputs even with active inputs
        ctl_i = 12'h208; src_i = 16'h1111; dst_i = 16'h2222;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_o == 16'h0 && !dst_wr_o && !c_upd_o, "R11", "reset state",
              {res_o[15:1], dst_wr_o}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            fa = {n_o, z_o, c_o, v_o};
            ua = {n_upd_o, z_upd_o, c_upd_o, v_upd_o};
            check(res_o == VECS[i].res, tag, "result", res_o, VECS[i].res);
            check((fa & VECS[i].upd) == (VECS[i].flg & VECS[i].upd), tag, "flags",
                  {12'h0, fa & VECS[i].upd}, {12'h0, VECS[i].flg & VECS[i].upd});
            check({ua, dst_wr_o} == {VECS[i].upd, VECS[i].wr}, tag, "enables",
                  {11'h0, ua, dst_wr_o}, {11'h0, VECS[i].upd, VECS[i].wr});
        end

        // R11: one-edge latency; outputs hold until the next rising edge
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        drive(VECS[18]);
        #1;
        check(res_o == 16'h2143, "R11", "hold before edge", res_o, 16'h2143);
        @(posedge clk);
        @(negedge clk);
        check(res_o == 16'hAB12, "R11", "after edge", res_o, 16'hAB12);

        // R11: reset asserted mid-run clears outputs at the next edge
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(res_o == 16'h0 && !dst_wr_o, "R11", "reset mid-run",
              res_o, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule